// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block receives asynchronous serial characters from a single line that rests high. It does not run from a baud-rate clock. It works from a one-cycle enable pulse that arrives sixteen times per bit period. The line first passes through a two-stage synchroniser. The receiver waits for the line to go low, then confirms the start bit near the middle of the bit. It then reads the data bits, an optional parity bit and the stop bit, one bit period apart.

Every bit decision is a vote among three consecutive tick readings centred on the sampling point. A glitch that lasts a single tick cannot change a bit. A select input moves the start-bit check earlier in the bit period, so that short low pulses of the shortened-pulse infrared style are caught. Word length, parity enable and parity sense are taken from plain control pins when a start edge is detected. Each finished character leaves the block with its framing, parity and break flags and a one-cycle valid strobe.

The output stream has no ready input because a serial line cannot be paused. Data and flags hold their value only during the cycle in which `rx_valid` is high. The consumer must take them in that cycle, and the block never waits for a consumer.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset `rx_valid` is low, and no character is produced while the line stays high.
- R2: In normal mode (`sir_sel`=0) a low line seen on a tick starts a candidate frame. That tick is numbered 0. The start bit is voted from the readings on ticks 7, 8 and 9. If the vote is high, the start is false: the receiver returns to idle and emits nothing.
- R3: With `sir_sel`=1 the start bit is voted from ticks 3, 4 and 5. A start bit that is low for only ticks 0 to 6 is accepted, where normal mode rejects it.
- R4: Each following bit is voted 16 ticks after the previous one. The data bits are the first bits after the start bit and are placed LSB first. There are 5+`word_len` of them (`word_len` 0..3 selects 5..8 bits), and the unused upper bits of `rx_data` are zero.
- R5: Each bit value is the majority of three readings on consecutive ticks centred on the sampling point. A disturbance lasting one tick at the centre leaves the character unchanged.
- R6: When `par_en`=1, one parity bit follows the data bits. `par_odd`=0 expects an even number of ones across the data and parity bits, and `par_odd`=1 expects an odd number. A mismatch sets `rx_par_err`. When `par_en`=0 no parity bit is read and `rx_par_err` is 0.
- R7: A stop bit voted low sets `rx_frame_err`.
- R8: `rx_break` is set when every data bit, the parity bit (if enabled) and the stop bit are all zero.
- R9: `rx_valid` is high for exactly one clock per character, and data and flags are valid in that clock.
- R10: The bit counter and the receive state advance only on clocks where `tick16` is high. A line that goes low and returns high with no tick in between starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| sir_sel | input | 1 | 1 = early start-bit check (tick 4 centre) |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received character, LSB first on the line |
| rx_frame_err | output | 1 | Stop bit was low |
| rx_par_err | output | 1 | Parity mismatch |
| rx_break | output | 1 | All data, parity and stop bits were zero |

## Verification
The bench drives the line at tick resolution. This lets it place a start pulse that is low for only seven ticks. In normal mode that pulse must be dropped, and with the early check it must be accepted. A design with the wrong centre tick accepts or drops both.

The bench flips single ticks at bit centres and sends one-tick low spikes. A receiver that reads one sample instead of voting returns corrupt data or phantom characters.

Short words and both parity senses are covered, along with a deliberately wrong parity bit and a low stop bit with zero and non-zero data. These catch a misplaced bit index, stale upper bits, an inverted parity sense, and a break flag raised on an ordinary framing error.

A held-low line with no ticks checks that the counter does not advance without the enable.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic vote
);
  // readings from the two previous ticks; the current one is din
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= 2'b11;
    else if (tick) hist <= {hist[0], din};
  end

  assign vote = (hist[1] & hist[0]) | (hist[1] & din) | (hist[0] & din);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_vote_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MID_NORM = 8,
  parameter int MID_SIR  = 4,
  parameter int MAXW     = 8,
  parameter int WLW      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic            vote,
  input  logic            sir_sel,
  input  logic [WLW-1:0]  word_len,
  input  logic            par_en,
  input  logic            par_odd,
  output logic            rx_valid,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_frame_err,
  output logic            rx_par_err,
  output logic            rx_break
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(MAXW);
  localparam int MINW = MAXW - (2**WLW) + 1;
  localparam logic [CW-1:0] MIDN = CW'(MID_NORM);
  localparam logic [CW-1:0] MIDS = CW'(MID_SIR);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [MAXW-1:0] shreg;
  logic            par_acc;
  logic            seen_one;
  logic [BW-1:0]   c_last;
  logic            c_par;
  logic            c_odd;
  logic            c_sir;
  logic            eval;

  // tick index since start = cnt+1; evaluate one tick past the centre
  always_comb begin
    if (state == ST_START) eval = tick && (cnt == (c_sir ? MIDS : MIDN));
    else                   eval = tick && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      bidx         <= '0;
      shreg        <= '0;
      par_acc      <= 1'b0;
      seen_one     <= 1'b0;
      c_last       <= '0;
      c_par        <= 1'b0;
      c_odd        <= 1'b0;
      c_sir        <= 1'b0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
      rx_break     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        cnt <= cnt + 1'b1;
        case (state)
          ST_IDLE: begin
            if (!line) begin
              state    <= ST_START;
              cnt      <= '0;
              bidx     <= '0;
              shreg    <= '0;
              par_acc  <= 1'b0;
              seen_one <= 1'b0;
              c_last   <= BW'(word_len) + BW'(MINW - 1);
              c_par    <= par_en;
              c_odd    <= par_odd;
              c_sir    <= sir_sel;
            end
          end
          ST_START: begin
            if (eval) begin
              cnt   <= '0;
              state <= vote ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            if (eval) begin
              cnt         <= '0;
              shreg[bidx] <= vote;
              par_acc     <= par_acc ^ vote;
              seen_one    <= seen_one | vote;
              if (bidx == c_last) state <= c_par ? ST_PAR : ST_STOP;
              else                bidx  <= bidx + 1'b1;
            end
          end
          ST_PAR: begin
            if (eval) begin
              cnt      <= '0;
              par_acc  <= par_acc ^ vote;
              seen_one <= seen_one | vote;
              state    <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (eval) begin
              cnt          <= '0;
              state        <= ST_IDLE;
              rx_valid     <= 1'b1;
              rx_data      <= shreg;
              rx_frame_err <= ~vote;
              rx_par_err   <= c_par & (par_acc ^ c_odd);
              rx_break     <= ~seen_one & ~vote;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_break_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> (rx_frame_err && rx_data == '0));

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(state) && $stable(cnt)));

  p_no_par_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !c_par) |-> !rx_par_err);

  p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> ((BW+1)'(c_last) + 1'b1)) == '0));

  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && tick && line) |=> state == ST_IDLE);
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OVS         = 16,
  parameter int MID_NORM    = 8,
  parameter int MID_SIR     = 4,
  parameter int MAXW        = 8,
  parameter int WLW         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            rxd,
  input  logic            sir_sel,
  input  logic [WLW-1:0]  word_len,
  input  logic            par_en,
  input  logic            par_odd,
  output logic            rx_valid,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_frame_err,
  output logic            rx_par_err,
  output logic            rx_break
);
  logic line;
  logic vote;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line)
  );

  rx_vote3 u_vote (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick16),
    .din  (line),
    .vote (vote)
  );

  rx_frame_fsm #(
    .OVS     (OVS),
    .MID_NORM(MID_NORM),
    .MID_SIR (MID_SIR),
    .MAXW    (MAXW),
    .WLW     (WLW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .line        (line),
    .vote        (vote),
    .sir_sel     (sir_sel),
    .word_len    (word_len),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_frame_err(rx_frame_err),
    .rx_par_err  (rx_par_err),
    .rx_break    (rx_break)
  );
endmodule

// File: tb/sim_uart_rx_vote.sv
`timescale 1ns/1ps
module sim_uart_rx_vote;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic sir_sel = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic rx_valid;
  logic [7:0] rx_data;
  logic rx_frame_err, rx_par_err, rx_break;

  int n_chk = 0;
  int n_fail = 0;
  int nvalid = 0;
  logic [7:0] got_d = '0;
  logic got_fe = 1'b0, got_pe = 1'b0, got_brk = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_vote u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .sir_sel(sir_sel), .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_par_err(rx_par_err), .rx_break(rx_break)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      nvalid++;
      got_d   = rx_data;
      got_fe  = rx_frame_err;
      got_pe  = rx_par_err;
      got_brk = rx_break;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one tick slot = 4 clocks, tick in the last clock
  task automatic slot(input logic v);
    rxd = v;
    tick16 = 1'b0;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  function automatic logic [11:0] mk(input logic [7:0] d, input int nd,
                                     input bit pe, input bit po, input bit stopv);
    logic [11:0] b;
    logic p;
    b = '1;
    b[0] = 1'b0;
    p = po;
    for (int i = 0; i < nd; i++) begin
      b[1+i] = d[i];
      p = p ^ d[i];
    end
    if (pe) b[1+nd] = p;
    b[1+nd+(pe ? 1 : 0)] = stopv;
    return b;
  endfunction

  // short_start>0: start bit low only for slots below it; glitch flips one slot
  task automatic frame(input logic [11:0] bits, input int nb,
                       input int short_start, input int glitch_at);
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < 16; s++) begin
        logic v;
        v = bits[b];
        if (b == 0 && short_start > 0 && s >= short_start) v = 1'b1;
        if (b*16 + s == glitch_at) v = ~v;
        slot(v);
      end
    end
    repeat (24) slot(1'b1);
  endtask

  task automatic expect_char(input string tag, input int n0, input logic [7:0] d,
                             input bit fe, input bit pe, input bit brk);
    chk({tag, " count"}, nvalid, n0 + 1);
    chk({tag, " data"}, got_d, d);
    chk({tag, " frame"}, got_fe, fe);
    chk({tag, " parity"}, got_pe, pe);
    chk({tag, " break"}, got_brk, brk);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", rx_valid, 0);
    repeat (40) slot(1'b1);
    chk("R1 no char on idle line", nvalid, 0);
  endtask

  task automatic t_8n1;
    int n0 = nvalid;
    word_len = 2'd3; par_en = 0; sir_sel = 0;
    frame(mk(8'hA5, 8, 0, 0, 1), 10, 0, -1);
    expect_char("R4 R9 8N1 A5", n0, 8'hA5, 0, 0, 0);
    n0 = nvalid;
    frame(mk(8'h3C, 8, 0, 0, 1), 10, 0, -1);
    expect_char("R4 8N1 3C", n0, 8'h3C, 0, 0, 0);
  endtask

  task automatic t_short_word;
    int n0 = nvalid;
    word_len = 2'd0; par_en = 0;
    frame(mk(8'hF5, 5, 0, 0, 1), 7, 0, -1);
    expect_char("R4 5-bit upper zero", n0, 8'h15, 0, 0, 0);
    n0 = nvalid;
    word_len = 2'd2;
    frame(mk(8'h5A, 7, 0, 0, 1), 9, 0, -1);
    expect_char("R4 7-bit", n0, 8'h5A, 0, 0, 0);
  endtask

  task automatic t_parity;
    int n0 = nvalid;
    logic [11:0] b;
    word_len = 2'd3; par_en = 1; par_odd = 0;
    frame(mk(8'h07, 8, 1, 0, 1), 11, 0, -1);
    expect_char("R6 even ok", n0, 8'h07, 0, 0, 0);
    n0 = nvalid;
    b = mk(8'h07, 8, 1, 0, 1);
    b[9] = ~b[9];
    frame(b, 11, 0, -1);
    expect_char("R6 even bad", n0, 8'h07, 0, 1, 0);
    n0 = nvalid;
    par_odd = 1;
    frame(mk(8'h81, 8, 1, 1, 1), 11, 0, -1);
    expect_char("R6 odd ok", n0, 8'h81, 0, 0, 0);
    n0 = nvalid;
    frame(mk(8'h81, 8, 1, 0, 1), 11, 0, -1);
    expect_char("R6 odd bad", n0, 8'h81, 0, 1, 0);
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_framing;
    int n0 = nvalid;
    word_len = 2'd3; par_en = 0;
    frame(mk(8'h42, 8, 0, 0, 0), 10, 0, -1);
    expect_char("R7 low stop", n0, 8'h42, 1, 0, 0);
  endtask

  task automatic t_break;
    int n0 = nvalid;
    word_len = 2'd3; par_en = 1; par_odd = 0;
    frame(mk(8'h00, 8, 1, 0, 0), 11, 0, -1);
    expect_char("R8 break", n0, 8'h00, 1, 0, 1);
    par_en = 0;
  endtask

  task automatic t_false_start;
    int n0 = nvalid;
    sir_sel = 0;
    repeat (5) slot(1'b0);
    repeat (40) slot(1'b1);
    chk("R2 false start 5 ticks", nvalid, n0);
    slot(1'b0);
    repeat (40) slot(1'b1);
    chk("R5 one-tick spike no char", nvalid, n0);
  endtask

  task automatic t_sir;
    int n0 = nvalid;
    word_len = 2'd3; par_en = 0;
    sir_sel = 0;
    frame(mk(8'hFF, 8, 0, 0, 1), 10, 7, -1);
    chk("R2 normal rejects 7-tick start", nvalid, n0);
    sir_sel = 1;
    frame(mk(8'h3C, 8, 0, 0, 1), 10, 7, -1);
    expect_char("R3 sir accepts 7-tick start", n0, 8'h3C, 0, 0, 0);
    sir_sel = 0;
  endtask

  task automatic t_glitch;
    int n0 = nvalid;
    word_len = 2'd3; par_en = 0;
    frame(mk(8'hA5, 8, 0, 0, 1), 10, 0, 3*16 + 8);
    expect_char("R5 centre glitch bit2", n0, 8'hA5, 0, 0, 0);
    n0 = nvalid;
    frame(mk(8'hA5, 8, 0, 0, 1), 10, 0, 2*16 + 8);
    expect_char("R5 centre glitch bit1", n0, 8'hA5, 0, 0, 0);
  endtask

  task automatic t_no_tick;
    int n0 = nvalid;
    tick16 = 1'b0;
    rxd = 1'b0;
    repeat (200) @(negedge clk);
    rxd = 1'b1;
    repeat (40) slot(1'b1);
    chk("R10 low without tick ignored", nvalid, n0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_8n1();
    t_short_word();
    t_parity();
    t_framing();
    t_break();
    t_false_start();
    t_sir();
    t_glitch();
    t_no_tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule